// File: doc/BRIEF.md
# Fan PWM Controller with Status LED

This block drives the speed-control line of a four-wire fan with a fixed-frequency PWM signal. The duty setting is an 8-bit value that a quadrature rotary knob moves up or down in fixed steps. It stops at the lowest and highest settings. A new setting takes effect at the next PWM period boundary, so no period is cut short or stretched.

Pressing the knob's push switch copies the present setting into a stored-setting register and pulses a save strobe. The stored value is loaded as the active setting each time reset is applied. The stored register is not cleared by reset. At power-up it holds the mid-scale setting.

A single status LED shows the fan speed. It is dark at the lowest setting and lit at the highest setting. Between the two it blinks, and it blinks faster as the setting rises. After every save the LED gives three fixed-length flashes and then goes back to showing the speed.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: The PWM period is CLK_HZ/PWM_HZ clock cycles (P). For a setting d, the output is high for floor(d*P/256) cycles of each period. At d = 255 the output is high for the whole period, and at d = 0 it stays low.
- R2: A rising edge on enc_a while enc_b is low raises the setting by STEP. A rising edge on enc_a while enc_b is high lowers it by STEP. The result is clamped to the range 0 to 255.
- R3: The push switch is accepted only after its synchronised level has stayed high for DEB_CYCLES consecutive cycles. A shorter high pulse saves nothing.
- R4: An accepted press raises save_stb for exactly one cycle. In that same cycle save_duty shows the setting that was stored, and save_duty changes at no other time.
- R5: While rst is high, save_strb, pwm_out and led_out are low. After rst the active setting equals the stored value. The stored value is 128 at power-up and is not changed by rst.
- R6: When the setting is 0 and no save acknowledge is running, led_out is low.
- R7: When the setting is 255 and no save acknowledge is running, led_out is high.
- R8: When the setting is between 1 and 254, led_out toggles every BLINK_BASE - d*BLINK_STEP cycles.
- R9: After a save, led_out gives exactly three high pulses of ACK_HALF cycles, each followed by ACK_HALF low cycles. After that it returns to the behaviour in R6 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Knob quadrature phase A (asynchronous) |
| enc_b | input | 1 | Knob quadrature phase B (asynchronous) |
| btn | input | 1 | Knob push switch, high when pressed (asynchronous, may bounce) |
| pwm_out | output | 1 | Fan PWM control line |
| led_out | output | 1 | Status LED drive |
| save_stb | output | 1 | One-cycle pulse when a setting is stored |
| save_duty | output | 8 | Stored setting |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value | Effect |
|---|---|---|
| CLK_HZ | 2.2 MHz | Together with PWM_HZ, gives a PWM period of 100 cycles |
| DEB_CYCLES | 20 | Short debounce window |
| STEP | 16 | Large knob step |
| BLINK_BASE | 600 | Blink timing base |
| BLINK_STEP | 2 | Blink rate change per setting step |
| ACK_HALF | 40 | Save-acknowledge pulse length |

With these values both clamps are reached in a few knob turns, and the high time of a PWM period can be counted exactly. Blink intervals and the whole save acknowledge fit within a few hundred cycles. Because the stored register survives reset, the bench can save a setting, apply reset, and then read the restored setting from the PWM duty.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int DUTY_W = 8;
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;
  localparam logic [DUTY_W-1:0] DUTY_MID = 8'd128;

  function automatic logic [DUTY_W-1:0] step_duty(
    input logic [DUTY_W-1:0] cur,
    input logic              up,
    input logic              dn,
    input int                step
  );
    int v;
    v = int'(cur);
    if (up) v = v + step;
    else if (dn) v = v - step;
    if (v < 0) v = 0;
    if (v > int'(DUTY_MAX)) v = int'(DUTY_MAX);
    return DUTY_W'(v);
  endfunction
endpackage

// File: rtl/fan_input_cond.sv
module fan_input_cond #(
  parameter int DEB_CYCLES = 500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_a,
  input  logic enc_b,
  input  logic btn,
  output logic step_up,
  output logic step_dn,
  output logic press
);
  localparam int DCW = $clog2(DEB_CYCLES + 1);

  logic [1:0] a_s, b_s, k_s;
  logic       a_prev;
  logic       k_stable;
  logic [DCW-1:0] deb_cnt;

  // two-stage synchronisers
  always_ff @(posedge clk) begin
    if (rst) begin
      a_s    <= '0;
      b_s    <= '0;
      k_s    <= '0;
      a_prev <= 1'b0;
    end else begin
      a_s    <= {a_s[0], enc_a};
      b_s    <= {b_s[0], enc_b};
      k_s    <= {k_s[0], btn};
      a_prev <= a_s[1];
    end
  end

  // direction decode on rising phase A
  always_ff @(posedge clk) begin
    if (rst) begin
      step_up <= 1'b0;
      step_dn <= 1'b0;
    end else begin
      step_up <= a_s[1] & ~a_prev & ~b_s[1];
      step_dn <= a_s[1] & ~a_prev &  b_s[1];
    end
  end

  // debounce: level must differ from the accepted one for DEB_CYCLES cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      deb_cnt  <= '0;
      k_stable <= 1'b0;
      press    <= 1'b0;
    end else begin
      press <= 1'b0;
      if (k_s[1] != k_stable) begin
        if (deb_cnt == DCW'(DEB_CYCLES - 1)) begin
          deb_cnt  <= '0;
          k_stable <= k_s[1];
          press    <= k_s[1];
        end else begin
          deb_cnt <= deb_cnt + 1'b1;
        end
      end else begin
        deb_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int PERIOD = 2272,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] duty,
  output logic          pwm_out
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int PW = DW + CW + 1;
  localparam logic [DW-1:0] DMAX = '1;

  logic [CW-1:0] cnt_q, cnt_nx;
  logic [DW-1:0] lat_q, lat_nx;
  logic [PW-1:0] prod;
  logic [CW:0]   cmp_nx;
  logic          wrap;

  always_comb begin
    wrap   = (cnt_q == CW'(PERIOD - 1));
    cnt_nx = wrap ? '0 : cnt_q + 1'b1;
    lat_nx = wrap ? duty : lat_q;
    prod   = PW'(lat_nx) * PW'(PERIOD);
    if (lat_nx == DMAX) cmp_nx = (CW+1)'(PERIOD);
    else                cmp_nx = (CW+1)'(prod >> DW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      lat_q   <= '0;
      pwm_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      lat_q   <= lat_nx;
      pwm_out <= ({1'b0, cnt_nx} < cmp_nx);
    end
  end
endmodule

// File: rtl/fan_led_ctrl.sv
module fan_led_ctrl #(
  parameter int DW         = 8,
  parameter int BLINK_BASE = 12_750_000,
  parameter int BLINK_STEP = 40_000,
  parameter int ACK_HALF   = 5_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] duty,
  input  logic          save_evt,
  output logic          led_out,
  output logic          ack_busy
);
  localparam int HW = $clog2(BLINK_BASE + 1);
  localparam int AW = (ACK_HALF > 1) ? $clog2(ACK_HALF) : 1;
  localparam int ACK_PHASES = 6;
  localparam logic [DW-1:0] DMAX = '1;

  logic [HW-1:0] half, blink_cnt;
  logic          blink_q;
  logic [AW-1:0] ack_cnt;
  logic [2:0]    ack_phase;

  always_comb half = HW'(BLINK_BASE - int'(duty) * BLINK_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      blink_cnt <= '0;
      blink_q   <= 1'b0;
    end else if (blink_cnt >= half - 1'b1) begin
      blink_cnt <= '0;
      blink_q   <= ~blink_q;
    end else begin
      blink_cnt <= blink_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_busy  <= 1'b0;
      ack_cnt   <= '0;
      ack_phase <= '0;
    end else if (save_evt) begin
      ack_busy  <= 1'b1;
      ack_cnt   <= '0;
      ack_phase <= '0;
    end else if (ack_busy) begin
      if (ack_cnt == AW'(ACK_HALF - 1)) begin
        ack_cnt <= '0;
        if (ack_phase == 3'(ACK_PHASES - 1)) ack_busy  <= 1'b0;
        else                                 ack_phase <= ack_phase + 1'b1;
      end else begin
        ack_cnt <= ack_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                led_out <= 1'b0;
    else if (ack_busy)      led_out <= ~ack_phase[0];
    else if (duty == '0)    led_out <= 1'b0;
    else if (duty == DMAX)  led_out <= 1'b1;
    else                    led_out <= blink_q;
  end
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int PWM_HZ     = 22_000,
  parameter int DEB_CYCLES = 500_000,
  parameter int STEP       = 4,
  parameter int BLINK_BASE = 12_750_000,
  parameter int BLINK_STEP = 40_000,
  parameter int ACK_HALF   = 5_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              btn,
  output logic              pwm_out,
  output logic              led_out,
  output logic              save_stb,
  output logic [DUTY_W-1:0] save_duty
);
  localparam int PERIOD = CLK_HZ / PWM_HZ;

  logic step_up, step_dn, press;
  logic ack_busy;
  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] save_q = DUTY_MID;

  fan_input_cond #(.DEB_CYCLES(DEB_CYCLES)) u_in (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .btn(btn),
    .step_up(step_up), .step_dn(step_dn), .press(press)
  );

  always_ff @(posedge clk) begin
    if (rst) duty_q <= save_q;
    else     duty_q <= step_duty(duty_q, step_up, step_dn, STEP);
  end

  // stored setting survives reset
  always_ff @(posedge clk) begin
    if (!rst && press) save_q <= duty_q;
  end

  always_ff @(posedge clk) begin
    if (rst) save_stb <= 1'b0;
    else     save_stb <= press;
  end

  assign save_duty = save_q;

  fan_pwm_gen #(.PERIOD(PERIOD), .DW(DUTY_W)) u_pwm (
    .clk(clk), .rst(rst), .duty(duty_q), .pwm_out(pwm_out)
  );

  fan_led_ctrl #(
    .DW(DUTY_W), .BLINK_BASE(BLINK_BASE), .BLINK_STEP(BLINK_STEP), .ACK_HALF(ACK_HALF)
  ) u_led (
    .clk(clk), .rst(rst), .duty(duty_q), .save_evt(press & ~rst),
    .led_out(led_out), .ack_busy(ack_busy)
  );
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] duty,
  input logic          ack_busy,
  input logic          led_out,
  input logic          save_stb,
  input logic [DW-1:0] save_duty
);
  a_r4_stb_single: assert property (@(posedge clk) disable iff (rst)
    save_stb |=> !save_stb);

  a_r4_stored_value: assert property (@(posedge clk) disable iff (rst)
    save_stb |-> save_duty == $past(duty));

  a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
    !save_stb |-> $stable(save_duty));

  a_r6_led_dark: assert property (@(posedge clk) disable iff (rst)
    (duty == '0 && !ack_busy) |=> !led_out);

  a_r7_led_lit: assert property (@(posedge clk) disable iff (rst)
    (duty == '1 && !ack_busy) |=> led_out);
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(.DW(fan_pkg::DUTY_W)) u_chk (
  .clk(clk), .rst(rst), .duty(duty_q), .ack_busy(ack_busy),
  .led_out(led_out), .save_stb(save_stb), .save_duty(save_duty)
);

// File: tb/fan_pwm_ctrl_bench.sv
module fan_pwm_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 2_200_000;
  localparam int PWM_HZ = 22_000;
  localparam int P      = CLK_HZ / PWM_HZ;
  localparam int DEB    = 20;
  localparam int STEP   = 16;
  localparam int BBASE  = 600;
  localparam int BSTEP  = 2;
  localparam int ACKH   = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_a = 1'b0, enc_b = 1'b0, btn = 1'b0;
  logic pwm_out, led_out, save_stb;
  logic [7:0] save_duty;

  int checks = 0, failures = 0, stb_cnt = 0, cyc = 0;
  int exp_duty = 128;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_pwm_ctrl #(
    .CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ), .DEB_CYCLES(DEB), .STEP(STEP),
    .BLINK_BASE(BBASE), .BLINK_STEP(BSTEP), .ACK_HALF(ACKH)
  ) u_fan_pwm_ctrl (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .btn(btn),
    .pwm_out(pwm_out), .led_out(led_out), .save_stb(save_stb), .save_duty(save_duty)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (save_stb) stb_cnt <= stb_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cycles(4);
    check(pwm_out == 0 && led_out == 0 && save_stb == 0, "R5 outputs low in reset",
          {pwm_out, led_out, save_stb}, 0);
    rst = 1'b0;
    cycles(2);
  endtask

  function automatic int exp_high(input int d);
    return (d == 255) ? P : (d * P) / 256;
  endfunction

  task automatic t_pwm(input string req);
    int hi = 0;
    cycles(2 * P + 5);
    for (int i = 0; i < P; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check(hi == exp_high(exp_duty), req, hi, exp_high(exp_duty));
  endtask

  task automatic turn(input bit up, input int n);
    for (int i = 0; i < n; i++) begin
      enc_b = ~up;
      cycles(4);
      enc_a = 1'b1;
      cycles(4);
      enc_a = 1'b0;
      cycles(4);
      enc_b = 1'b0;
      cycles(4);
      exp_duty = up ? exp_duty + STEP : exp_duty - STEP;
      if (exp_duty > 255) exp_duty = 255;
      if (exp_duty < 0) exp_duty = 0;
    end
  endtask

  task automatic t_blink();
    int n = 0;
    logic prev;
    int exp = BBASE - exp_duty * BSTEP;
    prev = led_out;
    while (led_out == prev && n < 2000) begin @(negedge clk); n++; end
    prev = led_out;
    n = 0;
    while (led_out == prev && n < 2000) begin @(negedge clk); n++; end
    check(n == exp, "R8 blink half period", n, exp);
  endtask

  task automatic t_led_const(input logic lvl, input string req);
    int bad = 0;
    for (int i = 0; i < 800; i++) begin
      if (led_out !== lvl) bad++;
      @(negedge clk);
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic t_glitch();
    int s0 = stb_cnt;
    logic [7:0] d0 = save_duty;
    btn = 1'b1;
    cycles(DEB / 2);
    btn = 1'b0;
    cycles(3 * DEB);
    check(stb_cnt == s0, "R3 short press ignored", stb_cnt, s0);
    check(save_duty == d0, "R3 stored value unchanged", save_duty, d0);
  endtask

  // press and watch the acknowledge pattern (setting must be 0)
  task automatic t_save_ack();
    int s0 = stb_cnt, rises = 0, highs = 0;
    logic prev = led_out;
    btn = 1'b1;
    for (int i = 0; i < 500; i++) begin
      if (i == DEB + 20) btn = 1'b0;
      if (led_out && !prev) rises++;
      if (led_out) highs++;
      prev = led_out;
      @(negedge clk);
    end
    check(stb_cnt == s0 + 1, "R4 one save strobe", stb_cnt, s0 + 1);
    check(save_duty == exp_duty, "R4 stored value", save_duty, exp_duty);
    check(rises == 3, "R9 three ack pulses", rises, 3);
    check(highs == 3 * ACKH, "R9 ack on time", highs, 3 * ACKH);
  endtask

  task automatic t_save_plain();
    int s0 = stb_cnt;
    btn = 1'b1;
    cycles(DEB + 20);
    btn = 1'b0;
    cycles(DEB + 20 + 6 * ACKH);
    check(stb_cnt == s0 + 1, "R4 save strobe count", stb_cnt, s0 + 1);
    check(save_duty == exp_duty, "R4 save_duty value", save_duty, exp_duty);
  endtask

  initial begin
    fork
      begin
        cycles(3);
        check(save_duty == 128, "R5 power-up stored value", save_duty, 128);
        do_reset();
        t_pwm("R1 R5 default setting duty");
        t_blink();
        turn(1'b1, 8);
        t_pwm("R2 R1 clamp at maximum");
        t_led_const(1'b1, "R7 LED lit at maximum");
        turn(1'b0, 17);
        t_pwm("R2 R1 clamp at minimum");
        t_led_const(1'b0, "R6 LED dark at minimum");
        t_glitch();
        t_save_ack();
        t_led_const(1'b0, "R9 return to speed mode");
        turn(1'b1, 3);
        t_pwm("R2 R1 intermediate setting");
        t_blink();
        t_save_plain();
        turn(1'b0, 1);
        t_pwm("R2 step down");
        do_reset();
        exp_duty = 48;
        check(save_duty == 48, "R5 stored value kept through reset", save_duty, 48);
        t_pwm("R5 setting restored after reset");
      end
      begin
        while (cyc < 200_000) @(negedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200_000);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule